// File: doc/BRIEF.md
# Translation Table Pointer Walker

When the translation buffer misses, this block takes over the miss. It reads one entry from an in-memory translation table and decides whether that entry can refill the buffer. The table is direct mapped and indexed by virtual page number. It sits in a physically contiguous region aligned to its own size. Because of that alignment, the entry pointer is formed by splicing index bits from the faulting virtual address into a base address register. No adder is needed.

The walker handles one miss at a time. It computes the pointer and issues a single read for the 16-byte tag/data pair. It then compares the stored tag with the page number of the miss. A usable matching entry produces a fill pulse carrying the translation data and a retry indication. Any other outcome produces a slow-path pulse, which hands the miss on to software. Software reprograms the base and size inputs on each context switch. The walker samples them only when it accepts a miss.

Top module: `tsb_walker`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `fill_valid`, `retry` and `slow_miss` are all 0.
- R2: The read address equals `base_addr` with bits [12+n:0] replaced by `{miss_va[21+n:13], 4'b0000}`, where n is `base_size` (0..15). The table therefore holds 512·2^n entries of 16 bytes.
- R3: `base_addr` and `base_size` are sampled in the cycle a miss is accepted. A later change has no effect on that walk's address and applies to the next miss.
- R4: Each miss produces exactly one accepted read. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`, and `mem_req_valid` stays low after the handshake.
- R5: The response data packs the tag word in [63:0] and the data word in [127:64]. The entry is a hit when data-word bit 63 (valid) is 1 and tag-word bits [34:0] equal `miss_va[47:13]`. Tag-word bits above 34 are ignored. A hit raises `fill_valid` and `retry` for one cycle, with `fill_tte` equal to the data word, two clock edges after the response edge.
- R6: When the tag bits differ, `slow_miss` pulses for one cycle at that same point, and `fill_valid` and `retry` stay 0.
- R7: An entry with the valid bit clear takes the slow path even when its tag bits match.
- R8: `miss_ready` is low from the acceptance edge until the cycle after the result pulse, so only one miss is outstanding at a time.
- R9: `fill_valid` and `slow_miss` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle, miss accepted this cycle if offered |
| miss_va | input | VA_W | Faulting virtual address |
| base_addr | input | PA_W | Table base address (size aligned) |
| base_size | input | 4 | Table size exponent n |
| mem_req_valid | output | 1 | Read request for one table entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Entry address |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 2*TTE_W | {data word, tag word} |
| fill_valid | output | 1 | Translation data ready for a buffer fill |
| fill_tte | output | TTE_W | Translation data word |
| retry | output | 1 | Faulting access may be replayed |
| slow_miss | output | 1 | Entry unusable, escalate to the slow path |

## Verification
A wrong pointer latch or base sampling error appears at `mem_req_addr` on the first request cycle of the walk, so the bench changes the base inputs right after acceptance and compares the address. A controller state that is wrong shows up within a few cycles as one of: a duplicated request, a request that vanishes before ready, `miss_ready` returning too early, or a result pulse one cycle off. A bad tag or valid decision shows up as the wrong pulse two edges after the response. The bench drives random ready and response latency and checks each of these at fixed offsets.

// File: rtl/tsb_walker.sv
module tsb_walker #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int TTE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [VA_W-1:0]    miss_va,
  input  logic [PA_W-1:0]    base_addr,
  input  logic [3:0]         base_size,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [2*TTE_W-1:0] mem_rsp_data,
  output logic               fill_valid,
  output logic [TTE_W-1:0]   fill_tte,
  output logic               retry,
  output logic               slow_miss
);
  localparam int PG_SH = 13;
  localparam int VPN_W = VA_W - PG_SH;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CMP, S_FILL, S_MISS} state_t;
  state_t state;

  logic [VPN_W-1:0] vpn_q;
  logic [PA_W-1:0]  ptr_q;
  logic             sent_q;
  logic [TTE_W-1:0] tag_q, data_q;

  logic [PA_W-1:0] tbl_mask, idx_off, ptr_d;
  logic            hit;

  assign tbl_mask = (PA_W'(1) << (5'd13 + {1'b0, base_size})) - PA_W'(1);
  assign idx_off  = PA_W'({miss_va[VA_W-1:PG_SH], 4'b0000});
  assign ptr_d    = (base_addr & ~tbl_mask) | (idx_off & tbl_mask);
  assign hit      = data_q[TTE_W-1] && (tag_q[VPN_W-1:0] == vpn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sent_q <= 1'b0;
      vpn_q  <= '0;
      ptr_q  <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (miss_valid) begin
          vpn_q  <= miss_va[VA_W-1:PG_SH];
          ptr_q  <= ptr_d;
          sent_q <= 1'b0;
          state  <= S_READ;
        end
        S_READ: begin
          if (mem_req_valid && mem_req_ready) sent_q <= 1'b1;
          if (sent_q && mem_rsp_valid) begin
            tag_q  <= mem_rsp_data[TTE_W-1:0];
            data_q <= mem_rsp_data[2*TTE_W-1:TTE_W];
            state  <= S_CMP;
          end
        end
        S_CMP:   state <= hit ? S_FILL : S_MISS;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign miss_ready    = (state == S_IDLE);
  assign mem_req_valid = (state == S_READ) && !sent_q;
  assign mem_req_addr  = ptr_q;
  assign fill_valid    = (state == S_FILL);
  assign retry         = (state == S_FILL);
  assign fill_tte      = data_q;
  assign slow_miss     = (state == S_MISS);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R4
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[3:0] == 4'b0000); // R2
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && slow_miss)); // R9
  AST_PULSE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid && miss_ready); // R9
  AST_PULSE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    slow_miss |=> !slow_miss && miss_ready); // R9
  AST_FILL_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> fill_tte[TTE_W-1]); // R7
  AST_RETRY_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    retry == fill_valid); // R5
endmodule

// File: tb/sim_tsb_walker.sv
module sim_tsb_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready;
  logic [47:0] miss_va = '0;
  logic [39:0] base_addr = '0;
  logic [3:0]  base_size = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic fill_valid, retry, slow_miss;
  logic [63:0] fill_tte;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  tsb_walker u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_ptr(input logic [39:0] b, input logic [3:0] n, input logic [47:0] va);
    longint unsigned bytes = longint'(1) << (13 + n);
    longint unsigned ents  = longint'(512) << n;
    longint unsigned idx   = (longint'(va) >> 13) % ents;
    return 40'(longint'(b) - (longint'(b) % bytes) + idx * 16);
  endfunction

  function automatic bit exp_hit(input logic [63:0] tagw, input logic [63:0] dataw, input logic [47:0] va);
    return dataw[63] && (tagw[34:0] == va[47:13]);
  endfunction

  task automatic walk(input logic [47:0] va, input logic [39:0] b, input logic [3:0] n,
                      input logic [63:0] tagw, input logic [63:0] dataw);
    logic [39:0] ep = exp_ptr(b, n, va);
    bit eh = exp_hit(tagw, dataw, va);
    int reqs = 0, guard = 0;
    logic [39:0] got_addr = '0;
    @(negedge clk);
    base_addr = b; base_size = n; miss_va = va; miss_valid = 1'b1;
    chk(miss_ready == 1'b1, "R8 idle before miss", 64'(miss_ready), 64'd1);
    @(negedge clk);
    miss_valid = 1'b0;
    base_addr = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
    base_size = 4'($urandom);
    chk(miss_ready == 1'b0, "R8 busy after accept", 64'(miss_ready), 64'd0);
    while (reqs == 0 && guard < 40) begin
      mem_req_ready = 1'($urandom);
      if (mem_req_valid && mem_req_ready) begin reqs++; got_addr = mem_req_addr; end
      @(negedge clk);
      guard++;
    end
    mem_req_ready = 1'b0;
    chk(reqs == 1, "R4 request issued", 64'(reqs), 64'd1);
    chk(got_addr == ep, "R2 R3 entry address", 64'(got_addr), 64'(ep));
    for (int k = 0; k < int'($urandom % 4); k++) begin
      chk(!mem_req_valid, "R4 no second request", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = {dataw, tagw};
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = {$urandom, $urandom, $urandom, $urandom};
    chk(!fill_valid && !slow_miss, "R5 no result yet", {62'd0, fill_valid, slow_miss}, 64'd0);
    @(negedge clk);
    if (eh) begin
      chk(fill_valid && retry && !slow_miss, "R5 hit fill and retry",
          {61'd0, fill_valid, retry, slow_miss}, 64'd6);
      chk(fill_tte == dataw, "R5 fill data", fill_tte, dataw);
    end else begin
      chk(slow_miss && !fill_valid && !retry, "R6 R7 slow path",
          {61'd0, fill_valid, retry, slow_miss}, 64'd1);
    end
    chk(!miss_ready, "R8 busy during result", 64'(miss_ready), 64'd0);
    @(negedge clk);
    chk(miss_ready && !fill_valid && !slow_miss, "R9 single pulse then idle",
        {61'd0, miss_ready, fill_valid, slow_miss}, 64'd4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] va;
    logic [39:0] b;
    logic [3:0]  n;
    logic [63:0] t, d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !retry && !slow_miss, "R1 reset state",
        {59'd0, miss_ready, mem_req_valid, fill_valid, retry, slow_miss}, 64'h10);
    rst_n = 1'b1;
    va = 48'h1234_5678_A000;
    walk(va, 40'h00_8000_0000, 4'd0, {29'd0, va[47:13]}, 64'h8000_0000_0000_1234);
    va = 48'hFEDC_BA98_6000;
    walk(va, 40'hF0_0000_0000, 4'd15, {29'h1FFF_FFFF, va[47:13]}, 64'hC000_0000_00AB_CDEF);
    va = 48'h0000_0040_2000;
    walk(va, 40'h12_3456_789F, 4'd3, {29'd0, va[47:13]}, 64'h8000_0000_0000_0001);
    walk(va, 40'h00_4000_0000, 4'd2, {29'd0, va[47:13]}, 64'h7FFF_FFFF_FFFF_FFFF);
    walk(va, 40'h00_4000_0000, 4'd2, {29'd0, va[47:13] ^ 35'd1}, 64'h8000_0000_0000_0055);
    va = 48'hFFFF_FFFF_E000;
    walk(va, 40'hFF_FFFF_FFFF, 4'd7, {29'd0, va[47:13]}, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 40; i++) begin
      va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      b  = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      n  = 4'($urandom);
      d  = {$urandom, $urandom};
      t  = {$urandom, $urandom};
      if ($urandom % 2) t[34:0] = va[47:13];
      walk(va, b, n, t, d);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule